// File: doc/BRIEF.md
# I2C Target Register File

This block is a target (slave) on an I2C bus. It holds an array of 8-bit control registers that a bus master can write and read. SCL and SDA are oversampled by a system clock at least twenty times faster than the bus clock. The block finds START and STOP conditions and frames the bits into bytes. It answers only to its own 7-bit address. SDA is never driven high: the block only pulls the line low, through an output enable.

A write transfer carries the device address, then a register sub-address that loads the internal pointer, then any number of data bytes. Each data byte is stored at the pointer, and the pointer then steps forward. A read transfer has no sub-address of its own. It starts at the pointer left by the last write and steps forward after every byte it sends. The pointer wraps from the top register back to register 0. Every register value is also presented on a flat parallel output for use by the rest of the chip.

Top module: `i2c_regfile_target`

## Requirements
- R1: After a synchronous reset, the SDA output enable is low, every register reads 0 and the pointer is 0.
- R2: A first byte equal to {DEV_ADDR, direction} is acknowledged by pulling SDA low during the ninth SCL clock. Direction bit 0 means write and 1 means read. DEV_ADDR defaults to 7'h40, so the first byte is 0x80 for a write and 0x81 for a read.
- R3: A first byte with any other 7-bit address is not acknowledged. The block then drives nothing and changes nothing until the next START or STOP.
- R4: In a write transfer, the second byte loads the pointer and is acknowledged. Each later byte is acknowledged, written to the register at the pointer, and then advances the pointer by one.
- R5: In a read transfer, the block sends the register at the current pointer MSB first during the eight SCL clocks after each acknowledge. It advances the pointer after each byte.
- R6: When the master does not acknowledge a read byte (SDA high in the ninth clock), the block releases SDA and stays silent until START or STOP. The pointer has still advanced past that byte.
- R7: The pointer wraps from the highest register index to 0 on both writes and reads.
- R8: A repeated START at any point, including partway through a byte, returns the block to address reception. A partially received byte is discarded.
- R9: The SDA output enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe_o | output | 1 | When high, SDA is pulled low |
| regs_o | output | 8*2^REG_AW | All registers; register i sits in bits [8i+7:8i] |

## Verification
The bench builds the block with REG_AW = 4, which gives sixteen registers, and keeps the default address 7'h40. With sixteen registers, a three-byte burst from register 14 is enough to cross the wrap boundary. The whole register image can also be compared against a behavioural shadow on every clock. SCL runs at one fortieth of the system clock, which leaves room for the synchronizer delay while still exercising repeated STARTs in the middle of a byte.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned BITCNT_W = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_ACK,
        PH_TX,
        PH_MACK,
        PH_IGNORE
    } phase_e;

    typedef enum logic [1:0] {
        BK_ADDR,
        BK_SUB,
        BK_DATA
    } kind_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic [6:0] dev);
        return b[BYTE_W-1:1] == dev;
    endfunction

endpackage

// File: rtl/i2ct_bus_sampler.sv
module i2ct_bus_sampler
    import i2ct_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);

    localparam int unsigned TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_prev;
    logic                   sda_prev;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_pipe[TOP];
            sda_prev <= sda_pipe[TOP];
        end
    end

    always_comb begin
        ev_o.scl      = scl_pipe[TOP];
        ev_o.sda      = sda_pipe[TOP];
        ev_o.scl_rise = scl_pipe[TOP] & ~scl_prev;
        ev_o.scl_fall = ~scl_pipe[TOP] & scl_prev;
        ev_o.start    = scl_pipe[TOP] & scl_prev & sda_prev & ~sda_pipe[TOP];
        ev_o.stop     = scl_pipe[TOP] & scl_prev & ~sda_prev & sda_pipe[TOP];
    end

endmodule

// File: rtl/i2ct_reg_bank.sv
module i2ct_reg_bank
    import i2ct_pkg::*;
#(
    parameter int unsigned REG_AW = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we_i,
    input  logic [REG_AW-1:0]              waddr_i,
    input  logic [BYTE_W-1:0]              wdata_i,
    input  logic [REG_AW-1:0]              raddr_i,
    output logic [BYTE_W-1:0]              rdata_o,
    output logic [(2**REG_AW)*BYTE_W-1:0]  flat_o
);

    localparam int unsigned DEPTH = 2 ** REG_AW;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic [BYTE_W-1:0] cell_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q <= '0;
            end else if (we_i && (waddr_i == REG_AW'(i))) begin
                cell_q <= wdata_i;
            end
        end
        assign flat_o[i*BYTE_W +: BYTE_W] = cell_q;
    end

    assign rdata_o = flat_o[BYTE_W*int'(raddr_i) +: BYTE_W];

endmodule

// File: rtl/i2ct_framer.sv
module i2ct_framer
    import i2ct_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR = 7'h40,
    parameter int unsigned REG_AW   = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  bus_ev_t              ev_i,
    input  logic [BYTE_W-1:0]    rd_data_i,
    output logic [REG_AW-1:0]    ptr_o,
    output logic                 sda_oe_o,
    output logic                 wr_en_o,
    output logic [REG_AW-1:0]    wr_addr_o,
    output logic [BYTE_W-1:0]    wr_data_o
);

    localparam logic [BITCNT_W-1:0] FULL = BITCNT_W'(BYTE_W);

    phase_e               phase_q;
    kind_e                kind_q;
    logic                 rw_q;
    logic [BITCNT_W-1:0]  bitcnt_q;
    logic [BYTE_W-1:0]    sr_q;
    logic [REG_AW-1:0]    ptr_q;
    logic                 oe_q;
    logic                 mack_ok_q;
    logic                 wr_en_q;
    logic [REG_AW-1:0]    wr_addr_q;
    logic [BYTE_W-1:0]    wr_data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            kind_q    <= BK_ADDR;
            rw_q      <= 1'b0;
            bitcnt_q  <= '0;
            sr_q      <= '0;
            ptr_q     <= '0;
            oe_q      <= 1'b0;
            mack_ok_q <= 1'b0;
            wr_en_q   <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else begin
            wr_en_q <= 1'b0;
            if (ev_i.stop) begin
                phase_q <= PH_IDLE;
                oe_q    <= 1'b0;
            end else if (ev_i.start) begin
                phase_q  <= PH_RX;
                kind_q   <= BK_ADDR;
                bitcnt_q <= '0;
                oe_q     <= 1'b0;
            end else begin
                unique case (phase_q)
                    PH_RX: begin
                        if (ev_i.scl_rise && bitcnt_q != FULL) begin
                            sr_q     <= {sr_q[BYTE_W-2:0], ev_i.sda};
                            bitcnt_q <= bitcnt_q + BITCNT_W'(1);
                        end else if (ev_i.scl_fall && bitcnt_q == FULL) begin
                            bitcnt_q <= '0;
                            unique case (kind_q)
                                BK_ADDR: begin
                                    if (addr_hit(sr_q, DEV_ADDR)) begin
                                        rw_q    <= sr_q[0];
                                        phase_q <= PH_ACK;
                                        oe_q    <= 1'b1;
                                    end else begin
                                        phase_q <= PH_IGNORE;
                                    end
                                end
                                BK_SUB: begin
                                    ptr_q   <= sr_q[REG_AW-1:0];
                                    phase_q <= PH_ACK;
                                    oe_q    <= 1'b1;
                                end
                                default: begin
                                    wr_en_q   <= 1'b1;
                                    wr_addr_q <= ptr_q;
                                    wr_data_q <= sr_q;
                                    ptr_q     <= ptr_q + REG_AW'(1);
                                    phase_q   <= PH_ACK;
                                    oe_q      <= 1'b1;
                                end
                            endcase
                        end
                    end
                    PH_ACK: begin
                        if (ev_i.scl_fall) begin
                            bitcnt_q <= '0;
                            if (rw_q) begin
                                phase_q <= PH_TX;
                                sr_q    <= rd_data_i;
                                oe_q    <= ~rd_data_i[BYTE_W-1];
                            end else begin
                                phase_q <= PH_RX;
                                oe_q    <= 1'b0;
                                kind_q  <= (kind_q == BK_ADDR) ? BK_SUB : BK_DATA;
                            end
                        end
                    end
                    PH_TX: begin
                        if (ev_i.scl_rise) begin
                            bitcnt_q <= bitcnt_q + BITCNT_W'(1);
                        end else if (ev_i.scl_fall) begin
                            if (bitcnt_q == FULL) begin
                                phase_q  <= PH_MACK;
                                oe_q     <= 1'b0;
                                ptr_q    <= ptr_q + REG_AW'(1);
                                bitcnt_q <= '0;
                            end else begin
                                sr_q <= {sr_q[BYTE_W-2:0], 1'b0};
                                oe_q <= ~sr_q[BYTE_W-2];
                            end
                        end
                    end
                    PH_MACK: begin
                        if (ev_i.scl_rise) begin
                            mack_ok_q <= ~ev_i.sda;
                        end else if (ev_i.scl_fall) begin
                            if (mack_ok_q) begin
                                phase_q <= PH_TX;
                                sr_q    <= rd_data_i;
                                oe_q    <= ~rd_data_i[BYTE_W-1];
                            end else begin
                                phase_q <= PH_IGNORE;
                            end
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    assign ptr_o     = ptr_q;
    assign sda_oe_o  = oe_q;
    assign wr_en_o   = wr_en_q;
    assign wr_addr_o = wr_addr_q;
    assign wr_data_o = wr_data_q;

    AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IGNORE) |-> !oe_q); // R3
    AST_WRITE_IN_LOW: assert property (@(posedge clk) disable iff (rst)
        wr_en_q |-> (!ev_i.scl && !rw_q)); // R4
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (ptr_q != $past(ptr_q)) |-> ((ptr_q == $past(ptr_q) + REG_AW'(1)) || $past(kind_q == BK_SUB))); // R7
    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (rst)
        ev_i.start |=> (phase_q == PH_RX && kind_q == BK_ADDR && bitcnt_q == '0)); // R8
    AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_MACK && ev_i.scl_fall && !mack_ok_q && !ev_i.start && !ev_i.stop) |=> !oe_q); // R6

endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
    import i2ct_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR    = 7'h40,
    parameter int unsigned REG_AW      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          scl_i,
    input  logic                          sda_i,
    output logic                          sda_oe_o,
    output logic [(2**REG_AW)*BYTE_W-1:0] regs_o
);

    bus_ev_t             ev;
    logic [REG_AW-1:0]   ptr;
    logic [BYTE_W-1:0]   rd_data;
    logic                wr_en;
    logic [REG_AW-1:0]   wr_addr;
    logic [BYTE_W-1:0]   wr_data;

    i2ct_bus_sampler #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sampler (
        .clk  (clk),
        .rst  (rst),
        .scl_i(scl_i),
        .sda_i(sda_i),
        .ev_o (ev)
    );

    i2ct_framer #(
        .DEV_ADDR(DEV_ADDR),
        .REG_AW  (REG_AW)
    ) u_framer (
        .clk      (clk),
        .rst      (rst),
        .ev_i     (ev),
        .rd_data_i(rd_data),
        .ptr_o    (ptr),
        .sda_oe_o (sda_oe_o),
        .wr_en_o  (wr_en),
        .wr_addr_o(wr_addr),
        .wr_data_o(wr_data)
    );

    i2ct_reg_bank #(
        .REG_AW(REG_AW)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .we_i   (wr_en),
        .waddr_i(wr_addr),
        .wdata_i(wr_data),
        .raddr_i(ptr),
        .rdata_o(rd_data),
        .flat_o (regs_o)
    );

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        (sda_oe_o != $past(sda_oe_o)) |-> !ev.scl); // R9
    AST_BANK_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (regs_o[BYTE_W*int'($past(wr_addr)) +: BYTE_W] == $past(wr_data))); // R4

endmodule

// File: tb/i2c_regfile_target_bench.sv
`timescale 1ns/1ps
module i2c_regfile_target_bench;

    localparam int unsigned AW = 4;
    localparam int unsigned NREG = 2 ** AW;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [NREG*8-1:0] regs;

    always #2 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    i2c_regfile_target #(
        .DEV_ADDR(7'h40),
        .REG_AW  (AW)
    ) u_i2c_regfile_target (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (m_scl),
        .sda_i   (sda_line),
        .sda_oe_o(sda_oe),
        .regs_o  (regs)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit settled = 1'b0;
    logic prev_oe = 1'b0;
    logic [7:0] mdl [NREG];
    int mdl_ptr = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // per-clock reference comparison
    always @(negedge clk) begin
        if (!rst) begin
            if (settled) begin
                bit ok = 1'b1;
                int bad = 0;
                for (int i = 0; i < NREG; i++) begin
                    if (ok && regs[i*8 +: 8] !== mdl[i]) begin
                        ok = 1'b0;
                        bad = i;
                    end
                end
                chk(ok, "R4 register image", {24'd0, regs[bad*8 +: 8]}, {24'd0, mdl[bad]});
            end
            if (sda_oe !== prev_oe) chk(m_scl == 1'b0, "R9 oe change with scl", {31'd0, m_scl}, 32'd0);
            prev_oe = sda_oe;
        end
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
        wq();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        b = sda_line; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic write_byte(input logic [7:0] b, input bit mdl_wr, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            if (i == 0) settled = 1'b0;
            send_bit(b[i]);
        end
        recv_bit(ack);
        if (mdl_wr) begin
            mdl[mdl_ptr] = b;
            mdl_ptr = (mdl_ptr + 1) % NREG;
        end
        settled = 1'b1;
    endtask

    task automatic read_byte(input bit give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            recv_bit(b);
            d[i] = b;
        end
        send_bit(!give_ack);
    endtask

    // read one byte predicted from the model pointer
    task automatic read_expect(input bit give_ack, input string req);
        logic [7:0] d;
        logic [7:0] e;
        e = mdl[mdl_ptr];
        read_byte(give_ack, d);
        chk(d == e, req, {24'd0, d}, {24'd0, e});
        mdl_ptr = (mdl_ptr + 1) % NREG;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        wrap_up();
    end

    initial begin
        logic ack;
        logic [7:0] d;
        for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(sda_oe == 1'b0, "R1 oe", {31'd0, sda_oe}, 32'd0);
        chk(regs == '0, "R1 regs", regs[31:0], 32'd0);
        settled = 1'b1;

        // R2 / R4 write burst from 3
        bus_start();
        write_byte(8'h80, 1'b0, ack); chk(ack == 1'b0, "R2 write addr ack", {31'd0, ack}, 32'd0);
        write_byte(8'h03, 1'b0, ack); chk(ack == 1'b0, "R4 sub ack", {31'd0, ack}, 32'd0);
        mdl_ptr = 3;
        write_byte(8'hA1, 1'b1, ack); chk(ack == 1'b0, "R4 data ack", {31'd0, ack}, 32'd0);
        write_byte(8'hB2, 1'b1, ack); chk(ack == 1'b0, "R4 data ack", {31'd0, ack}, 32'd0);
        write_byte(8'hC3, 1'b1, ack); chk(ack == 1'b0, "R4 data ack", {31'd0, ack}, 32'd0);
        bus_stop();

        // R5 read from pointer set by sub-address only write
        bus_start();
        write_byte(8'h80, 1'b0, ack);
        write_byte(8'h02, 1'b0, ack); mdl_ptr = 2;
        bus_stop();
        bus_start();
        write_byte(8'h81, 1'b0, ack); chk(ack == 1'b0, "R2 read addr ack", {31'd0, ack}, 32'd0);
        read_expect(1'b1, "R5 read byte");
        read_expect(1'b1, "R5 read byte");
        read_expect(1'b0, "R5 read last");
        // R6 silent after master NACK
        read_byte(1'b0, d); chk(d == 8'hFF, "R6 silent after nack", {24'd0, d}, 32'hFF);
        bus_stop();
        bus_start();
        write_byte(8'h81, 1'b0, ack);
        read_expect(1'b0, "R6 pointer advanced by nacked byte");
        bus_stop();

        // R7 wrap on write and read
        bus_start();
        write_byte(8'h80, 1'b0, ack);
        write_byte(8'h0E, 1'b0, ack); mdl_ptr = 14;
        write_byte(8'h11, 1'b1, ack);
        write_byte(8'h22, 1'b1, ack);
        write_byte(8'h33, 1'b1, ack); chk(ack == 1'b0, "R7 write across wrap", {31'd0, ack}, 32'd0);
        bus_stop();
        bus_start();
        write_byte(8'h80, 1'b0, ack);
        write_byte(8'h0F, 1'b0, ack); mdl_ptr = 15;
        bus_stop();
        bus_start();
        write_byte(8'h81, 1'b0, ack);
        read_expect(1'b1, "R7 read top");
        read_expect(1'b0, "R7 read wrapped");
        bus_stop();

        // R3 foreign address ignored
        bus_start();
        write_byte(8'h84, 1'b0, ack); chk(ack == 1'b1, "R3 foreign addr nack", {31'd0, ack}, 32'd1);
        write_byte(8'h04, 1'b0, ack); chk(ack == 1'b1, "R3 byte ignored", {31'd0, ack}, 32'd1);
        write_byte(8'h5C, 1'b0, ack); chk(ack == 1'b1, "R3 byte ignored", {31'd0, ack}, 32'd1);
        bus_stop();
        bus_start();
        write_byte(8'h81, 1'b0, ack);
        read_expect(1'b0, "R3 pointer untouched");
        bus_stop();
        bus_start();
        write_byte(8'h85, 1'b0, ack); chk(ack == 1'b1, "R3 foreign read nack", {31'd0, ack}, 32'd1);
        read_byte(1'b0, d); chk(d == 8'hFF, "R3 no data driven", {24'd0, d}, 32'hFF);
        bus_stop();

        // R8 repeated START mid-byte
        bus_start();
        write_byte(8'h80, 1'b0, ack);
        write_byte(8'h08, 1'b0, ack); mdl_ptr = 8;
        write_byte(8'h5A, 1'b1, ack);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        bus_start();
        write_byte(8'h80, 1'b0, ack); chk(ack == 1'b0, "R8 addr after restart", {31'd0, ack}, 32'd0);
        write_byte(8'h08, 1'b0, ack); mdl_ptr = 8;
        bus_start();
        write_byte(8'h81, 1'b0, ack); chk(ack == 1'b0, "R8 read after restart", {31'd0, ack}, 32'd0);
        read_expect(1'b1, "R8 written byte");
        read_expect(1'b0, "R8 partial byte dropped");
        bus_stop();

        repeat (20) @(negedge clk);
        wrap_up();
    end

endmodule